// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block closes counted loops for a word-addressed instruction sequencer. No branch instruction is needed and no cycle is lost. A start command supplies the first address of the loop body, an end address and a nonzero pass count. The block then marks a loop as running.

Each time an instruction completes, the sequencer presents the PC it would normally move to next. If a loop is running and that address equals the end address, the block decrements its pass counter. When passes remain, it overrides the next PC with the loop's first address in the same cycle. When the last pass finishes, it lets the sequential PC through and drops the running flag.

The block also holds the PC register that the sequencer steps. Reset clears the PC, both loop addresses, the counter and the running flag. The end address names the first word after the loop body: reaching it is what ends a pass.

Top module: `hwloop_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `pc_o` to 0, `active_o` to 0, both loop addresses to 0 and the pass counter to 0. After reset, a step whose `npc_i` is 0 gives no redirect.
- R2: A start command (`start_i`=1) with a nonzero `count_i` loads the loop top, the loop end and the count at the rising edge, and sets `active_o` from the next cycle.
- R3: A start command with `count_i`=0 is ignored. When idle, `active_o` stays 0. When a loop is running, that loop goes on unchanged.
- R4: On a step (`step_i`=1) while `active_o`=1, with `npc_i` equal to the loop end and more than one pass left, `redirect_o`=1 and `pc_next_o` equals the loop top in the same cycle, and the counter drops by one.
- R5: On such a match with exactly one pass left, `redirect_o`=0, `pc_next_o` equals `npc_i`, and `active_o` is 0 from the next cycle.
- R6: With no step, no running loop, or `npc_i` different from the loop end, `redirect_o`=0 and `pc_next_o` equals `npc_i`.
- R7: `pc_o` takes the value of `pc_next_o` at each rising edge where `step_i`=1, and holds otherwise.
- R8: The pass counter is nonzero whenever a match is evaluated.
- R9: When a start and a step fall in the same cycle, the step's match is evaluated on the old loop state, and the new loop's values replace the old ones at that edge.
- R10: A loop whose top equals its end repeats a single word, giving count-1 redirects and then exiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-loop command |
| top_i | input | AW | First word of the loop body |
| end_i | input | AW | Address whose arrival closes a pass |
| count_i | input | CW | Number of passes (0 ignored) |
| step_i | input | 1 | An instruction completes this cycle |
| npc_i | input | AW | Sequential next PC from the sequencer |
| pc_next_o | output | AW | Next PC after loop override (combinational) |
| redirect_o | output | 1 | Override taken this cycle |
| pc_o | output | AW | Current PC register |
| active_o | output | 1 | Loop in progress |

## Verification
A wrong pass count shows at the ports at the end of the loop. Too many passes gives an extra redirect on the last match. Too few passes gives an early fall of `active_o`. Either error appears on the final pass, so the bench runs loops of one, two, three and four passes and checks every redirect. A stale end or top address shows as a wrong `pc_next_o` on the very first match. A running flag that is lost or stuck shows within one step, because a zero-count command or a concurrent start is followed at once by a step at the old end address.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  localparam int DEF_AW = 16;
  localparam int DEF_CW = 16;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_BACK = 2'd1,
    ACT_EXIT = 2'd2
  } hwl_act_e;
endpackage

// File: rtl/hwl_match.sv
module hwl_match
  import hwl_pkg::*;
#(
  parameter int AW = DEF_AW,
  parameter int CW = DEF_CW
) (
  input  logic          step_i,
  input  logic          active_i,
  input  logic [AW-1:0] npc_i,
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] count_i,
  output hwl_act_e      act_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic hit;
  assign hit = step_i && active_i && (npc_i == end_i);

  always_comb begin
    act_o = ACT_NONE;
    if (hit) begin
      if (count_i > ONE) act_o = ACT_BACK;
      else               act_o = ACT_EXIT;
    end
  end
endmodule

// File: rtl/hwl_state.sv
module hwl_state
  import hwl_pkg::*;
#(
  parameter int AW = DEF_AW,
  parameter int CW = DEF_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] count_i,
  input  hwl_act_e      act_i,
  output logic [AW-1:0] top_o,
  output logic [AW-1:0] end_o,
  output logic [CW-1:0] count_o,
  output logic          active_o
);
  logic load;
  assign load = start_i && (count_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_o    <= '0;
      end_o    <= '0;
      count_o  <= '0;
      active_o <= 1'b0;
    end else if (load) begin
      top_o    <= top_i;
      end_o    <= end_i;
      count_o  <= count_i;
      active_o <= 1'b1;
    end else begin
      case (act_i)
        ACT_BACK: count_o <= count_o - CW'(1);
        ACT_EXIT: begin
          count_o  <= count_o - CW'(1);
          active_o <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hwl_pcreg.sv
module hwl_pcreg #(
  parameter int AW = hwl_pkg::DEF_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [AW-1:0] pc_next_i,
  output logic [AW-1:0] pc_o
);
  always_ff @(posedge clk) begin
    if (rst)         pc_o <= '0;
    else if (step_i) pc_o <= pc_next_i;
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwl_pkg::*;
#(
  parameter int AW = DEF_AW,
  parameter int CW = DEF_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] count_i,
  input  logic          step_i,
  input  logic [AW-1:0] npc_i,
  output logic [AW-1:0] pc_next_o,
  output logic          redirect_o,
  output logic [AW-1:0] pc_o,
  output logic          active_o
);
  logic [AW-1:0] top_q;
  logic [AW-1:0] end_q;
  logic [CW-1:0] cnt_q;
  hwl_act_e      act;

  hwl_match #(.AW(AW), .CW(CW)) match_i (
    .step_i   (step_i),
    .active_i (active_o),
    .npc_i    (npc_i),
    .end_i    (end_q),
    .count_i  (cnt_q),
    .act_o    (act)
  );

  hwl_state #(.AW(AW), .CW(CW)) state_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .top_i    (top_i),
    .end_i    (end_i),
    .count_i  (count_i),
    .act_i    (act),
    .top_o    (top_q),
    .end_o    (end_q),
    .count_o  (cnt_q),
    .active_o (active_o)
  );

  assign redirect_o = (act == ACT_BACK);
  assign pc_next_o  = redirect_o ? top_q : npc_i;

  hwl_pcreg #(.AW(AW)) pcreg_i (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step_i),
    .pc_next_i (pc_next_o),
    .pc_o      (pc_o)
  );
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [CW-1:0] count_i,
  input logic          step_i,
  input logic [AW-1:0] npc_i,
  input logic [AW-1:0] pc_next_o,
  input logic          redirect_o,
  input logic [AW-1:0] pc_o,
  input logic          active_o,
  input logic [AW-1:0] top_q,
  input logic [AW-1:0] end_q,
  input logic [CW-1:0] cnt_q
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !active_o && cnt_q == '0));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && count_i != '0) |=> (active_o && cnt_q == $past(count_i)));

  assert_zero_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (start_i && count_i == '0 && !active_o) |=> !active_o);

  assert_redirect_to_top_R4: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (pc_next_o == top_q && active_o && step_i && npc_i == end_q));

  assert_last_pass_exits_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && active_o && npc_i == end_q && cnt_q == CW'(1) && !start_i) |=> !active_o);

  assert_no_redirect_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!active_o || !step_i) |-> !redirect_o);

  assert_pc_follows_R7: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (pc_o == $past(pc_next_o)));

  assert_pc_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pc_o));

  assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    (active_o && step_i && npc_i == end_q) |-> (cnt_q != '0));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .count_i    (count_i),
  .step_i     (step_i),
  .npc_i      (npc_i),
  .pc_next_o  (pc_next_o),
  .redirect_o (redirect_o),
  .pc_o       (pc_o),
  .active_o   (active_o),
  .top_q      (top_q),
  .end_q      (end_q),
  .cnt_q      (cnt_q)
);

// File: tb/hwloop_ctrl_tb_top.sv
module hwloop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NV = 19;

  typedef struct packed {
    logic          st;
    logic [15:0]   top;
    logic [15:0]   endv;
    logic [15:0]   cnt;
    logic          stp;
    logic [15:0]   npc;
    logic [15:0]   e_nxt;
    logic          e_red;
    logic          e_act;
    logic [15:0]   e_pc;
  } vec_t;

  // st, top, end, cnt, step, npc | exp pc_next, redirect, active after, pc after
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 16'd10, 16'd14, 16'd3, 1'b0, 16'd0,  16'd0,  1'b0, 1'b1, 16'd0},  // R2
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd11, 16'd11, 1'b0, 1'b1, 16'd11}, // R6
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd14, 16'd10, 1'b1, 1'b1, 16'd10}, // R4
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b0, 16'd14, 16'd14, 1'b0, 1'b1, 16'd10}, // R6 R7
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd14, 16'd10, 1'b1, 1'b1, 16'd10}, // R4
    '{1'b1, 16'd50, 16'd12, 16'd0, 1'b1, 16'd12, 16'd12, 1'b0, 1'b1, 16'd12}, // R3
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd14, 16'd14, 1'b0, 1'b0, 16'd14}, // R5
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd14, 16'd14, 1'b0, 1'b0, 16'd14}, // R6
    '{1'b1, 16'd20, 16'd21, 16'd0, 1'b0, 16'd0,  16'd0,  1'b0, 1'b0, 16'd14}, // R3
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd21, 16'd21, 1'b0, 1'b0, 16'd21}, // R3
    '{1'b1, 16'd30, 16'd32, 16'd1, 1'b1, 16'd32, 16'd32, 1'b0, 1'b1, 16'd32}, // R9
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd32, 16'd32, 1'b0, 1'b0, 16'd32}, // R5
    '{1'b1, 16'd5,  16'd6,  16'd2, 1'b0, 16'd0,  16'd0,  1'b0, 1'b1, 16'd32}, // R2
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd6,  16'd5,  1'b1, 1'b1, 16'd5},  // R4
    '{1'b1, 16'd40, 16'd41, 16'd4, 1'b1, 16'd6,  16'd6,  1'b0, 1'b1, 16'd6},  // R9
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd41, 16'd40, 1'b1, 1'b1, 16'd40}, // R4
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd41, 16'd40, 1'b1, 1'b1, 16'd40}, // R4
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd41, 16'd40, 1'b1, 1'b1, 16'd40}, // R4
    '{1'b0, 16'd0,  16'd0,  16'd0, 1'b1, 16'd41, 16'd41, 1'b0, 1'b0, 16'd41}  // R5
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] top_i = '0;
  logic [AW-1:0] end_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          step_i = 1'b0;
  logic [AW-1:0] npc_i = '0;
  logic [AW-1:0] pc_next_o;
  logic          redirect_o;
  logic [AW-1:0] pc_o;
  logic          active_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwloop_ctrl #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .top_i(top_i), .end_i(end_i),
    .count_i(count_i), .step_i(step_i), .npc_i(npc_i), .pc_next_o(pc_next_o),
    .redirect_o(redirect_o), .pc_o(pc_o), .active_o(active_o)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [15:0] tp, input logic [15:0] en,
                       input logic [15:0] ct, input logic sp, input logic [15:0] np);
    @(negedge clk);
    start_i = st; top_i = tp; end_i = en; count_i = ct; step_i = sp; npc_i = np;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc_o after reset", pc_o, 16'd0);
    chk("R1 active_o after reset", 16'(active_o), 16'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: end address cleared to 0 but no loop runs
    drive(1'b0, 16'd0, 16'd0, 16'd0, 1'b1, 16'd0);
    chk("R1 redirect_o at npc 0", 16'(redirect_o), 16'd0);
    after_edge();

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].st, VEC[i].top, VEC[i].endv, VEC[i].cnt, VEC[i].stp, VEC[i].npc);
      chk($sformatf("R4 R6 pc_next_o vec %0d", i), pc_next_o, VEC[i].e_nxt);
      chk($sformatf("R4 R5 redirect_o vec %0d", i), 16'(redirect_o), 16'(VEC[i].e_red));
      after_edge();
      chk($sformatf("R2 R3 R5 R9 active_o vec %0d", i), 16'(active_o), 16'(VEC[i].e_act));
      chk($sformatf("R7 pc_o vec %0d", i), pc_o, VEC[i].e_pc);
    end

    // R10: single-word loop, top == end, three passes
    drive(1'b1, 16'd7, 16'd7, 16'd3, 1'b0, 16'd0);
    after_edge();
    chk("R10 active after start", 16'(active_o), 16'd1);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 16'd0, 16'd0, 16'd0, 1'b1, 16'd7);
      chk($sformatf("R10 redirect pass %0d", k), 16'(redirect_o), (k < 2) ? 16'd1 : 16'd0);
      chk($sformatf("R10 pc_next pass %0d", k), pc_next_o, 16'd7);
      after_edge();
    end
    chk("R10 active after last pass", 16'(active_o), 16'd0);

    // R1: reset in the middle of a running loop
    drive(1'b1, 16'd100, 16'd104, 16'd9, 1'b0, 16'd0);
    after_edge();
    drive(1'b0, 16'd0, 16'd0, 16'd0, 1'b1, 16'd103);
    after_edge();
    @(negedge clk);
    rst = 1'b1; step_i = 1'b1; npc_i = 16'd104;
    after_edge();
    chk("R1 pc_o mid-loop reset", pc_o, 16'd0);
    chk("R1 active_o mid-loop reset", 16'(active_o), 16'd0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 16'd0, 16'd0, 16'd0, 1'b1, 16'd104);
    chk("R1 no redirect after reset", 16'(redirect_o), 16'd0);
    after_edge();
    chk("R7 pc_o after reset step", pc_o, 16'd104);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule